// File: doc/BRIEF.md
# Quadrant-Packed Image Rotation Streamer

This block emits a square image, rotated about its centre by a requested angle, as a raster-scan stream with one word per clock. The source image lives in an external single-ported RAM. Each RAM word packs four copies of a source pixel: the image as stored, and the image turned by one, two and three quarter-turns. Each copy carries its own mask bit. The block computes one rotated source address per output pixel, in output raster order, so it reads the RAM out of order. A single read returns the same residual rotation applied to all four quarter-turned images, which gives four rotations of the image per pass. Any angle is therefore a quarter-turn plus a residual angle of 0 to 89 degrees, and this block handles only the residual angle.

For each output pixel the source coordinate comes from a fixed-point rotation with per-angle sine and cosine tables. The result is rounded to the nearest pixel, and no interpolation is done. When the source coordinate falls outside the image, the block emits an all-zero word, so every mask bit is clear and downstream logic skips the pixel. The stream carries a valid flag, a marker on the first word and a done marker on the last word.

Top module: `quad_rotate_streamer`

## Requirements
- R1: The output word has four 9-bit lanes. Lane i occupies bits 9i+8..9i. Its mask bit is bit 9i+8 and its pixel is bits 9i+7..9i. Lane 0 is the unrotated image and lane 3 is the image turned by three quarter-turns. For an in-range pixel, the block passes the RAM word through unchanged.
- R2: The coefficients for angle index a are 8-bit unsigned values with 7 fractional bits: c = round(cos(a°)·128) and s = round(sin(a°)·128). The rounding is floor(v·128 + 0.5).
- R3: For output column x and row y, with centre C = W/2, dx = x−C and dy = y−C. The source column is sx = ((dx·c − dy·s + 64) >>> 7) + C. The source row is sy = ((dx·s + dy·c + 64) >>> 7) + C. The read address is sy·W + sx, with the row in the upper bits.
- R4: If sx or sy lies outside 0..W−1, the block still emits the word as valid, and the word is all zeros.
- R5: Output is in raster order, row by row and column by column, with exactly W·W valid words on consecutive cycles.
- R6: Start is sampled at a clock edge. The first valid word appears after the fourth clock edge that follows. The RAM returns data one cycle after the address.
- R7: The first marker is high only with the first word of a rotation. The done marker is high only with its last word.
- R8: A start pulse is ignored from acceptance up to and including the cycle that carries the done marker.
- R9: A start pulse with an angle index of 90 or more is ignored.
- R10: During reset, out_valid, out_first, out_done and rd_en are low.
- R11: The block issues exactly one RAM read per output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a rotation |
| angle | input | 7 | Residual angle index in degrees, 0..89 |
| rd_en | output | 1 | RAM read strobe |
| rd_addr | output | 2·IMG_LOG2 | RAM address, row in the upper half |
| rd_data | input | 36 | RAM word, valid one cycle after rd_en |
| out_valid | output | 1 | Output word valid |
| out_word | output | 36 | Four packed rotated pixels with masks |
| out_first | output | 1 | First word of the rotation |
| out_done | output | 1 | Last word of the rotation |

## Verification
The embedded properties check the following on every cycle:
- both markers ride only on valid words;
- the stream has no gaps before the done marker;
- every output word is preceded by a RAM read two cycles earlier;
- an out-of-range coordinate yields a zero word.

Only the bench scenarios can show the following:
- the exact source pixel chosen for each output position at several angles, including the identity angle and the angles near 45 and 89;
- the four-edge latency;
- the rejection of a start request that arrives mid-rotation, in the done cycle, or with an angle of 90.

// File: rtl/quad_rotate_streamer.sv
module quad_rotate_streamer #(
  parameter int IMG_LOG2 = 8,
  parameter int ANGLES   = 90
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [6:0]              angle,
  output logic                    rd_en,
  output logic [2*IMG_LOG2-1:0]   rd_addr,
  input  logic [35:0]             rd_data,
  output logic                    out_valid,
  output logic [35:0]             out_word,
  output logic                    out_first,
  output logic                    out_done
);
  localparam int W    = 1 << IMG_LOG2;
  localparam int AW   = 2 * IMG_LOG2;
  localparam int SW   = IMG_LOG2 + 12;
  localparam logic [AW-1:0] LAST = AW'(W * W - 1);
  localparam logic signed [SW-1:0] CTR_S = SW'(W / 2);
  localparam logic signed [SW-1:0] W_S   = SW'(W);
  localparam logic signed [SW-1:0] RND_S = SW'(64);
  localparam real PI = 3.14159265358979323846;

  function automatic logic [ANGLES*8-1:0] build_tab(input bit want_sin);
    logic [ANGLES*8-1:0] t;
    real rad, v;
    t = '0;
    for (int a = 0; a < ANGLES; a++) begin
      rad = a * PI / 180.0;
      v = want_sin ? $sin(rad) : $cos(rad);
      t[a*8 +: 8] = 8'($rtoi(v * 128.0 + 0.5));
    end
    return t;
  endfunction

  localparam logic [ANGLES*8-1:0] COS_TAB = build_tab(1'b0);
  localparam logic [ANGLES*8-1:0] SIN_TAB = build_tab(1'b1);

  // control
  logic            busy, run;
  logic [AW-1:0]   pix;
  logic [7:0]      cos_q, sin_q;
  logic            accept;

  assign accept = start && !busy && (int'(angle) < ANGLES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      run   <= 1'b0;
      pix   <= '0;
      cos_q <= '0;
      sin_q <= '0;
    end else begin
      if (accept) begin
        busy  <= 1'b1;
        run   <= 1'b1;
        pix   <= '0;
        cos_q <= COS_TAB[{angle, 3'b000} +: 8];
        sin_q <= SIN_TAB[{angle, 3'b000} +: 8];
      end else begin
        if (run) begin
          pix <= pix + 1'b1;
          if (pix == LAST) run <= 1'b0;
        end
        if (out_done) busy <= 1'b0;
      end
    end
  end

  // stage 0: centred coordinates
  logic signed [SW-1:0] dx, dy, cs, ss;
  assign dx = $signed(SW'(pix[IMG_LOG2-1:0])) - CTR_S;
  assign dy = $signed(SW'(pix[AW-1:IMG_LOG2])) - CTR_S;
  assign cs = $signed(SW'(cos_q));
  assign ss = $signed(SW'(sin_q));

  // stage 1: products
  logic signed [SW-1:0] p_xc, p_ys, p_xs, p_yc;
  logic v1, f1, l1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; f1 <= 1'b0; l1 <= 1'b0;
      p_xc <= '0; p_ys <= '0; p_xs <= '0; p_yc <= '0;
    end else begin
      v1   <= run;
      f1   <= run && (pix == '0);
      l1   <= run && (pix == LAST);
      p_xc <= dx * cs;
      p_ys <= dy * ss;
      p_xs <= dx * ss;
      p_yc <= dy * cs;
    end
  end

  // stage 2: rounding, bounds, address
  logic signed [SW-1:0] sx, sy;
  logic                 inb;
  assign sx  = ((p_xc - p_ys + RND_S) >>> 7) + CTR_S;
  assign sy  = ((p_xs + p_yc + RND_S) >>> 7) + CTR_S;
  assign inb = (sx >= 0) && (sx < W_S) && (sy >= 0) && (sy < W_S);

  logic inb2, f2, l2;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_en <= 1'b0; rd_addr <= '0;
      inb2 <= 1'b0; f2 <= 1'b0; l2 <= 1'b0;
    end else begin
      rd_en   <= v1;
      rd_addr <= {sy[IMG_LOG2-1:0], sx[IMG_LOG2-1:0]};
      inb2    <= inb;
      f2      <= f1;
      l2      <= l1;
    end
  end

  // stage 3: RAM access in flight
  logic v3, inb3, f3, l3;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v3 <= 1'b0; inb3 <= 1'b0; f3 <= 1'b0; l3 <= 1'b0;
    end else begin
      v3   <= rd_en;
      inb3 <= inb2;
      f3   <= f2;
      l3   <= l2;
    end
  end

  // stage 4: output
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_first <= 1'b0;
      out_done  <= 1'b0;
    end else begin
      out_valid <= v3;
      out_word  <= (v3 && inb3) ? rd_data : '0;
      out_first <= v3 && f3;
      out_done  <= v3 && l3;
    end
  end

  p_first_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);
  p_done_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> out_valid);
  p_gapless_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_done) |=> out_valid);
  p_read_feeds_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rd_en, 2));
  p_oob_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (v3 && !inb3) |=> (out_word == '0));
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_done) |=> busy);
endmodule

// File: tb/tb_quad_rotate_streamer.sv
module tb_quad_rotate_streamer;
  localparam int L = 6;
  localparam int W = 1 << L;
  localparam int C = W / 2;
  localparam real PI = 3.14159265358979323846;
  // {check_ignored_start, angle}
  localparam logic [7:0] RUNS [6] = '{8'd0, 8'h81, 8'd30, 8'hAD, 8'd60, 8'hD9};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [6:0] angle = '0;
  logic rd_en, out_valid, out_first, out_done;
  logic [2*L-1:0] rd_addr;
  logic [35:0] rd_data = '0, out_word;
  int vecs = 0, fails = 0, rd_cnt = 0;

  always #4 clk = ~clk;

  quad_rotate_streamer #(.IMG_LOG2(L), .ANGLES(90)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .angle(angle),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_word(out_word),
    .out_first(out_first), .out_done(out_done));

  function automatic logic [35:0] img_word(input int a);
    logic [35:0] w;
    for (int i = 0; i < 4; i++) begin
      w[9*i+8]   = ((a * 7 + i * 3) % 5) != 0;
      w[9*i +: 8] = 8'((a * 13 + i * 61 + (a >> 6) * 29) & 255);
    end
    return w;
  endfunction

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= img_word(int'(rd_addr));
      rd_cnt  <= rd_cnt + 1;
    end
  end

  function automatic logic [35:0] expect_word(input int ang, input int k);
    int c, s, dx, dy, sx, sy;
    c  = $rtoi($cos(ang * PI / 180.0) * 128.0 + 0.5);
    s  = $rtoi($sin(ang * PI / 180.0) * 128.0 + 0.5);
    dx = (k % W) - C;
    dy = (k / W) - C;
    sx = ((dx * c - dy * s + 64) >>> 7) + C;
    sy = ((dx * s + dy * c + 64) >>> 7) + C;
    if (sx < 0 || sx >= W || sy < 0 || sy >= W) return '0;
    return img_word(sy * W + sx);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
      check(!out_valid && !rd_en, req, {out_valid, rd_en}, 2'b00);
    end
  endtask

  initial begin
    #1200000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check(!out_valid && !out_first && !out_done && !rd_en, "R10",
          {out_valid, out_first, out_done, rd_en}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 6; r++) begin
      int ang;
      bit poke;
      ang  = int'(RUNS[r][6:0]);
      poke = RUNS[r][7];
      rd_cnt = 0;
      start = 1'b1; angle = 7'(ang);
      @(negedge clk);
      start = 1'b0;
      // R6: nothing valid before the fourth edge after start
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check(!out_valid, "R6", out_valid, 1'b0);
      end
      for (int k = 0; k < W * W; k++) begin
        logic [35:0] e;
        @(negedge clk);
        // R8: start while busy (mid-run and in the done cycle) must be ignored
        start = poke && (k == 100 || k == W * W - 1);
        angle = poke ? 7'd17 : 7'(ang);
        e = expect_word(ang, k);
        // R1 R2 R3 R4 R5 R7
        check(out_valid && out_word == e && out_first == (k == 0) && out_done == (k == W * W - 1),
              "R1 R2 R3 R4 R5 R7",
              {out_valid, out_first, out_done, out_word}, {1'b1, k == 0, k == W * W - 1, e});
      end
      quiet(8, "R5 R8");
      check(rd_cnt == W * W, "R11", rd_cnt, W * W);
    end

    // R9: out-of-range angle is ignored
    start = 1'b1; angle = 7'd90;
    quiet(10, "R9");
    start = 1'b1; angle = 7'd127;
    quiet(10, "R9");

    // after rejected starts, a valid start still runs (R9, R6)
    start = 1'b1; angle = 7'd0;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    check(out_valid && out_first && out_word == expect_word(0, 0), "R9 R6",
          {out_valid, out_first, out_word}, {2'b11, expect_word(0, 0)});

    // R10: reset mid-stream clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!out_valid && !rd_en && !out_done, "R10", {out_valid, rd_en, out_done}, 3'b0);
    rst_n = 1'b1;
    quiet(6, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule